// File: doc/BRIEF.md
# Debug Mailbox with Access Lock

This block passes 32-bit words in both directions between an on-chip processor and an external debugger. Each side has its own simple register port with a small word address, a write strobe, a read strobe and 32-bit write and read data. Read data is combinational from the address and the current state. Any side effect of an access takes effect at the next rising clock edge.

There is one inbound word register, written by the debugger and read by the processor, and one outbound word register, written by the processor and read by the debugger. Each register has a pending flag. The flag is set when the owner of the register writes it and is cleared when the other side reads it. Both flags appear in a status word and can raise a maskable interrupt to the processor. A lock register lets processor software force the debug port reset. While that reset is forced, the debugger side of the block is inert. Two identifier words return parameter values.

Top module: `dbg_mailbox`

## Requirements
- R1: A debugger write to debugger address 0 stores the word and sets the inbound pending flag (status bit 30) at the next edge. The processor reads the stored word at processor address 0.
- R2: A processor read at processor address 0 clears the inbound pending flag at the next edge. Without such a read, the flag holds.
- R3: A processor write to processor address 1 stores the word and sets the outbound pending flag (status bit 31). The debugger reads the word at debugger address 1, and the processor can read it back at address 1.
- R4: A debugger read at debugger address 1 clears the outbound pending flag at the next edge.
- R5: When a store and a consuming read of the same word register fall in the same cycle, the flag ends set and the new word is stored.
- R6: The interrupt-enable word sits at processor address 3, with enable bit 30 for the inbound flag and enable bit 31 for the outbound flag; it resets to 0. The interrupt output is high exactly when some flag is set together with its enable.
- R7: Bit 0 of the lock word at processor address 4 drives the forced debug-port reset output one edge after it is written. The bit resets to 0.
- R8: While the lock is set, debugger writes are ignored. Debugger reads return 0 and do not clear the outbound flag.
- R9: The status word is at processor address 2 and debugger address 2. Its bits 29..0 read 0. Writes to processor addresses 2, 5, 6 and 7 change nothing. Unmapped addresses read 0.
- R10: Processor address 5 returns the identifier parameter. Address 6 returns the extension parameter when bit 31 of the identifier is 1, and 0 otherwise.
- R11: After reset both flags, both word registers, the interrupt output and the reset-forcing output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 3 | Processor word address |
| cpuWr | input | 1 | Processor write strobe |
| cpuRd | input | 1 | Processor read strobe |
| cpuWdata | input | 32 | Processor write data |
| cpuRdata | output | 32 | Processor read data |
| dbgAddr | input | 2 | Debugger word address |
| dbgWr | input | 1 | Debugger write strobe |
| dbgRd | input | 1 | Debugger read strobe |
| dbgWdata | input | 32 | Debugger write data |
| dbgRdata | output | 32 | Debugger read data |
| irq | output | 1 | Processor interrupt |
| tapForceRst | output | 1 | Forced reset for the debug test access port |

## Verification
The bench drives a store and a consuming read into the same register in one cycle. A design that let the clear win would lose a word and leave the flag low. It also issues debugger accesses while the lock is set. A design that failed to gate them would let a locked-out debugger plant words or silently drain the outbound flag. It writes the read-only and unmapped addresses with all-ones data; any stray decode would surface as a nonzero status field or a changed enable. A second instance with the extension bit clear shows whether the extension word is suppressed or leaks its parameter.

// File: rtl/dbg_mbox_pkg.sv
package dbg_mbox_pkg;
  localparam int CPU_AW = 3;
  localparam int DBG_AW = 2;

  localparam logic [CPU_AW-1:0] CPU_INBOX  = 3'd0;
  localparam logic [CPU_AW-1:0] CPU_OUTBOX = 3'd1;
  localparam logic [CPU_AW-1:0] CPU_STATUS = 3'd2;
  localparam logic [CPU_AW-1:0] CPU_IEN    = 3'd3;
  localparam logic [CPU_AW-1:0] CPU_LOCK   = 3'd4;
  localparam logic [CPU_AW-1:0] CPU_ID     = 3'd5;
  localparam logic [CPU_AW-1:0] CPU_EXTID  = 3'd6;

  localparam logic [DBG_AW-1:0] DBG_INBOX  = 2'd0;
  localparam logic [DBG_AW-1:0] DBG_OUTBOX = 2'd1;
  localparam logic [DBG_AW-1:0] DBG_STATUS = 2'd2;

  typedef struct packed {
    logic inLoad;
    logic inTake;
    logic outLoad;
    logic outTake;
    logic ienLoad;
    logic lockLoad;
  } mboxStrobes_t;
endpackage

// File: rtl/dbg_mbox_ctrl.sv
module dbg_mbox_ctrl
  import dbg_mbox_pkg::*;
(
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic [DBG_AW-1:0] dbgAddr,
  input  logic              dbgWr,
  input  logic              dbgRd,
  input  logic              locked,
  output mboxStrobes_t      strb,
  output logic              dbgOpen
);
  always_comb begin
    dbgOpen       = !locked;
    strb          = '0;
    strb.inLoad   = dbgOpen && dbgWr && (dbgAddr == DBG_INBOX);
    strb.inTake   = cpuRd && (cpuAddr == CPU_INBOX);
    strb.outLoad  = cpuWr && (cpuAddr == CPU_OUTBOX);
    strb.outTake  = dbgOpen && dbgRd && (dbgAddr == DBG_OUTBOX);
    strb.ienLoad  = cpuWr && (cpuAddr == CPU_IEN);
    strb.lockLoad = cpuWr && (cpuAddr == CPU_LOCK);
  end
endmodule

// File: rtl/dbg_mbox_dp.sv
module dbg_mbox_dp
  import dbg_mbox_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] ID_VALUE  = '0,
  parameter logic [DATA_W-1:0] EXT_VALUE = '0,
  parameter int                EXT_BIT   = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  mboxStrobes_t      strb,
  input  logic              dbgOpen,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DBG_AW-1:0] dbgAddr,
  input  logic [DATA_W-1:0] dbgWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [DATA_W-1:0] dbgRdata,
  output logic              rxPend,
  output logic              txPend,
  output logic              locked,
  output logic              irq
);
  localparam int OUT_BIT = DATA_W - 1;
  localparam int IN_BIT  = DATA_W - 2;

  logic [DATA_W-1:0] inWord, outWord, statusWord, extWord;
  logic              ienIn, ienOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inWord <= '0;
      rxPend <= 1'b0;
    end else if (strb.inLoad) begin
      inWord <= dbgWdata;
      rxPend <= 1'b1;
    end else if (strb.inTake) begin
      rxPend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outWord <= '0;
      txPend  <= 1'b0;
    end else if (strb.outLoad) begin
      outWord <= cpuWdata;
      txPend  <= 1'b1;
    end else if (strb.outTake) begin
      txPend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ienIn  <= 1'b0;
      ienOut <= 1'b0;
      locked <= 1'b0;
    end else begin
      if (strb.ienLoad) begin
        ienIn  <= cpuWdata[IN_BIT];
        ienOut <= cpuWdata[OUT_BIT];
      end
      if (strb.lockLoad) locked <= cpuWdata[0];
    end
  end

  generate
    if (ID_VALUE[EXT_BIT]) begin : g_ext
      assign extWord = EXT_VALUE;
    end else begin : g_noext
      assign extWord = '0;
    end
  endgenerate

  always_comb begin
    statusWord          = '0;
    statusWord[OUT_BIT] = txPend;
    statusWord[IN_BIT]  = rxPend;
  end

  always_comb begin
    unique case (cpuAddr)
      CPU_INBOX:  cpuRdata = inWord;
      CPU_OUTBOX: cpuRdata = outWord;
      CPU_STATUS: cpuRdata = statusWord;
      CPU_IEN: begin
        cpuRdata          = '0;
        cpuRdata[OUT_BIT] = ienOut;
        cpuRdata[IN_BIT]  = ienIn;
      end
      CPU_LOCK: begin
        cpuRdata    = '0;
        cpuRdata[0] = locked;
      end
      CPU_ID:    cpuRdata = ID_VALUE;
      CPU_EXTID: cpuRdata = extWord;
      default:   cpuRdata = '0;
    endcase
  end

  always_comb begin
    dbgRdata = '0;
    if (dbgOpen) begin
      if (dbgAddr == DBG_OUTBOX)      dbgRdata = outWord;
      else if (dbgAddr == DBG_STATUS) dbgRdata = statusWord;
    end
  end

  assign irq = (rxPend && ienIn) || (txPend && ienOut);
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import dbg_mbox_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] ID_VALUE  = 32'h8A5B_1234,
  parameter logic [DATA_W-1:0] EXT_VALUE = 32'h0000_00C3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  input  logic [DBG_AW-1:0] dbgAddr,
  input  logic              dbgWr,
  input  logic              dbgRd,
  input  logic [DATA_W-1:0] dbgWdata,
  output logic [DATA_W-1:0] dbgRdata,
  output logic              irq,
  output logic              tapForceRst
);
  mboxStrobes_t strb;
  logic dbgOpen, rxPend, txPend, locked;

  dbg_mbox_ctrl u_ctrl (
    .cpuAddr(cpuAddr), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .dbgAddr(dbgAddr), .dbgWr(dbgWr), .dbgRd(dbgRd),
    .locked(locked), .strb(strb), .dbgOpen(dbgOpen)
  );

  dbg_mbox_dp #(
    .DATA_W(DATA_W), .ID_VALUE(ID_VALUE), .EXT_VALUE(EXT_VALUE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dbgOpen(dbgOpen),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .dbgAddr(dbgAddr), .dbgWdata(dbgWdata),
    .cpuRdata(cpuRdata), .dbgRdata(dbgRdata),
    .rxPend(rxPend), .txPend(txPend), .locked(locked), .irq(irq)
  );

  assign tapForceRst = locked;
endmodule

// File: rtl/dbg_mailbox_chk.sv
module dbg_mailbox_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        cpuAddr,
  input logic              cpuWr,
  input logic              cpuRd,
  input logic [DATA_W-1:0] cpuWdata,
  input logic [DATA_W-1:0] cpuRdata,
  input logic [1:0]        dbgAddr,
  input logic              dbgWr,
  input logic              dbgRd,
  input logic              irq,
  input logic              tapForceRst,
  input logic              rxPend,
  input logic              txPend
);
  a_r1_in_sets: assert property (@(posedge clk) disable iff (!rstN)
    (dbgWr && dbgAddr == 2'd0 && !tapForceRst) |=> rxPend);

  a_r2_in_holds: assert property (@(posedge clk) disable iff (!rstN)
    (rxPend && !(cpuRd && cpuAddr == 3'd0)) |=> rxPend);

  a_r3_out_sets: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuAddr == 3'd1) |=> txPend);

  a_r4_out_clears: assert property (@(posedge clk) disable iff (!rstN)
    (dbgRd && dbgAddr == 2'd1 && !tapForceRst && !(cpuWr && cpuAddr == 3'd1)) |=> !txPend);

  a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (rxPend || txPend));

  a_r7_lock_from_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tapForceRst) |-> $past(cpuWr && cpuAddr == 3'd4 && cpuWdata[0]));

  a_r8_locked_no_inbound: assert property (@(posedge clk) disable iff (!rstN)
    (tapForceRst && !rxPend) |=> !rxPend);

  a_r9_status_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr == 3'd2) |-> (cpuRdata[DATA_W-3:0] == '0));
endmodule

bind dbg_mailbox dbg_mailbox_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/dbg_mailbox_bench.sv
module dbg_mailbox_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [2:0]  cpuAddr = '0;
  logic        cpuWr = 0, cpuRd = 0;
  logic [31:0] cpuWdata = '0, cpuRdata;
  logic [1:0]  dbgAddr = '0;
  logic        dbgWr = 0, dbgRd = 0;
  logic [31:0] dbgWdata = '0, dbgRdata;
  logic        irq, tapForceRst;
  logic [31:0] neRdata, neDbgRdata;
  logic        neIrq, neLock;

  dbg_mailbox u_dbg_mailbox (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .dbgAddr(dbgAddr), .dbgWr(dbgWr),
    .dbgRd(dbgRd), .dbgWdata(dbgWdata), .dbgRdata(dbgRdata), .irq(irq),
    .tapForceRst(tapForceRst)
  );

  // extension bit clear: extension word must read 0 (R10)
  dbg_mailbox #(.ID_VALUE(32'h0A5B_1234), .EXT_VALUE(32'h0000_00C3)) u_noext (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWr(1'b0), .cpuRd(1'b0),
    .cpuWdata(32'h0), .cpuRdata(neRdata), .dbgAddr(2'd0), .dbgWr(1'b0),
    .dbgRd(1'b0), .dbgWdata(32'h0), .dbgRdata(neDbgRdata), .irq(neIrq),
    .tapForceRst(neLock)
  );

  int nChecks = 0, nFails = 0;

  // behavioural reference state
  logic [31:0] mIn, mOut;
  logic mInP, mOutP, mIenIn, mIenOut, mLock;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mIn = 0; mOut = 0; mInP = 0; mOutP = 0; mIenIn = 0; mIenOut = 0; mLock = 0;
    end else begin
      automatic bit lk = mLock;
      if (dbgWr && dbgAddr == 0 && !lk) begin mIn = dbgWdata; mInP = 1; end
      else if (cpuRd && cpuAddr == 0) mInP = 0;
      if (cpuWr && cpuAddr == 1) begin mOut = cpuWdata; mOutP = 1; end
      else if (dbgRd && dbgAddr == 1 && !lk) mOutP = 0;
      if (cpuWr && cpuAddr == 3) begin mIenIn = cpuWdata[30]; mIenOut = cpuWdata[31]; end
      if (cpuWr && cpuAddr == 4) mLock = cpuWdata[0];
    end
  end

  function automatic logic [31:0] mStatus();
    return {mOutP, mInP, 30'd0};
  endfunction

  function automatic logic [31:0] expCpu(input logic [2:0] a);
    case (a)
      0: return mIn;
      1: return mOut;
      2: return mStatus();
      3: return {mIenOut, mIenIn, 30'd0};
      4: return {31'd0, mLock};
      5: return 32'h8A5B_1234;
      6: return 32'h0000_00C3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] expDbg(input logic [1:0] a);
    if (mLock) return 0;
    if (a == 1) return mOut;
    if (a == 2) return mStatus();
    return 0;
  endfunction

  function automatic string cpuTag(input logic [2:0] a);
    case (a)
      0: return "R1";
      1: return "R3";
      2: return "R9";
      3: return "R6";
      4: return "R7";
      5, 6: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    check(cpuTag(cpuAddr), cpuRdata, expCpu(cpuAddr));
    check(mLock ? "R8" : "R4", dbgRdata, expDbg(dbgAddr));
    check("R6", {31'd0, irq}, {31'd0, (mInP && mIenIn) || (mOutP && mIenOut)});
    check("R7", {31'd0, tapForceRst}, {31'd0, mLock});
  endtask

  task automatic step(input logic cw, input logic cr, input logic [2:0] ca, input logic [31:0] cd,
                      input logic dw, input logic dr, input logic [1:0] da, input logic [31:0] dd);
    @(negedge clk);
    cpuWr = cw; cpuRd = cr; cpuAddr = ca; cpuWdata = cd;
    dbgWr = dw; dbgRd = dr; dbgAddr = da; dbgWdata = dd;
    #1 compareAll();
  endtask

  task automatic idle(input logic [2:0] ca, input logic [1:0] da);
    step(0, 0, ca, 0, 0, 0, da, 0);
  endtask

  initial begin
    #2_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    // R11 reset state
    #12;
    check("R11", {30'd0, irq, tapForceRst}, 32'd0);
    cpuAddr = 2; #1 check("R11", cpuRdata, 32'd0);
    cpuAddr = 0; #1 check("R11", cpuRdata, 32'd0);
    @(negedge clk); rstN = 1;
    idle(2, 2);

    // R1 inbound store, R6 irq with enable
    step(1, 0, 3, 32'hC000_0000, 0, 0, 2, 0);
    step(0, 0, 2, 0, 1, 0, 0, 32'hDEAD_BEEF);
    idle(2, 2);
    check("R1", cpuRdata, 32'h4000_0000);
    check("R6", {31'd0, irq}, 32'd1);
    idle(0, 2);
    // R2 consume
    step(0, 1, 0, 0, 0, 0, 2, 0);
    idle(2, 2);
    check("R2", cpuRdata, 32'd0);
    // R3 outbound, R4 debugger consume
    step(1, 0, 1, 32'h1234_5678, 0, 0, 1, 0);
    idle(2, 1);
    check("R3", dbgRdata, 32'h1234_5678);
    step(0, 0, 2, 0, 0, 1, 1, 0);
    idle(2, 2);
    check("R4", cpuRdata, 32'd0);
    // R5 same-cycle store and consume, both directions
    step(0, 0, 2, 0, 1, 0, 0, 32'h1111_0000);
    step(1, 1, 0, 32'h2222_0000, 1, 0, 0, 32'h3333_0000);
    step(1, 0, 1, 32'h4444_0000, 0, 1, 1, 0);
    idle(2, 2);
    check("R5", cpuRdata, 32'hC000_0000);
    idle(0, 1);
    check("R5", cpuRdata, 32'h3333_0000);
    check("R5", dbgRdata, 32'h4444_0000);
    // R9 writes to read-only and unmapped addresses
    for (int a = 2; a < 8; a++) if (a != 3 && a != 4) step(1, 0, a[2:0], 32'hFFFF_FFFF, 0, 0, 2, 0);
    idle(3, 2);
    check("R9", cpuRdata, 32'hC000_0000);
    // R10
    idle(5, 3); check("R10", cpuRdata, 32'h8A5B_1234);
    idle(6, 3); check("R10", cpuRdata, 32'h0000_00C3);
    check("R10", neRdata, 32'd0);
    // R7 lock, R8 locked debugger inert
    step(0, 1, 0, 0, 0, 1, 1, 0);
    step(1, 0, 4, 32'h1, 0, 0, 2, 0);
    idle(4, 2);
    check("R7", {31'd0, tapForceRst}, 32'd1);
    step(1, 0, 1, 32'h5555_AAAA, 1, 0, 0, 32'h7777_7777);
    step(0, 0, 2, 0, 0, 1, 1, 0);
    idle(2, 1);
    check("R8", cpuRdata, 32'h8000_0000);
    check("R8", dbgRdata, 32'd0);
    step(1, 0, 4, 32'h0, 0, 0, 2, 0);
    idle(2, 1);
    check("R7", {31'd0, tapForceRst}, 32'd0);
    check("R8", dbgRdata, 32'h5555_AAAA);

    // randomised traffic against the reference model every cycle
    for (int i = 0; i < 4000; i++) begin
      automatic logic [2:0] ca = 3'($urandom_range(0, 7));
      automatic logic cw = ($urandom_range(0, 3) == 0);
      automatic logic [31:0] cd = $urandom;
      if (ca == 4 && $urandom_range(0, 3) != 0) cd[0] = 1'b0;
      step(cw, $urandom_range(0, 2) == 0, ca, cd,
           $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0,
           2'($urandom_range(0, 3)), $urandom);
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule